// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the purely combinational control unit of a single-cycle RISC datapath. A 6-bit opcode goes into a main decoder. The main decoder produces nine control lines:

- three multiplexer selects;
- three write and memory enables;
- a 2-bit ALU-operation class;
- a branch line.

A second stage combines the operation class with the 6-bit function field and produces a 3-bit ALU operation code. A last stage ANDs the branch line with the ALU zero flag to select the next program counter. PC+4 is the default next PC and needs no control line.

The datapath instantiates the block once. It feeds the block the current instruction's opcode and function fields plus the ALU zero flag. The outputs steer the register file, the ALU, the data memory and the PC multiplexer within the same cycle.

Top module: `cpu_ctrl_unit`

## Requirements
- R1: Opcode 000000 (register-register) drives dst_sel=1, opb_sel=0, wb_sel=0, rf_we=1, dmem_re=0, dmem_we=0, op_class=2'b10, br=0.
- R2: Opcode 100011 (load word) drives dst_sel=0, opb_sel=1, wb_sel=1, rf_we=1, dmem_re=1, dmem_we=0, op_class=2'b00, br=0.
- R3: Opcode 101011 (store word) drives dst_sel=0, opb_sel=1, wb_sel=0, rf_we=0, dmem_re=0, dmem_we=1, op_class=2'b00, br=0. For this opcode the two selects whose value does not matter are driven to 0.
- R4: Opcode 000100 (branch if equal) drives dst_sel=0, opb_sel=0, wb_sel=0, rf_we=0, dmem_re=0, dmem_we=0, op_class=2'b01, br=1.
- R5: Every other opcode drives all nine control lines to 0 (op_class=2'b00).
- R6: The ALU operation is add (alu_op=3'd0) when op_class is 00, and subtract (alu_op=3'd1) when op_class is 01. The function field is ignored for both classes.
- R7: When op_class is 10, the function field selects the ALU operation:
  - 100000 gives add (0);
  - 100010 gives subtract (1);
  - 100100 gives AND (2);
  - 100101 gives OR (3);
  - 101010 gives set-less-than (4);
  - any other code gives add (0).
- R8: pc_sel is 1 (branch target) only when br=1 and alu_zero=1. Otherwise pc_sel is 0 (PC+4).
- R9: dmem_re and dmem_we are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| alu_zero | input | 1 | ALU result-is-zero flag |
| dst_sel | output | 1 | Register destination select: 1 = rd field, 0 = rt field |
| opb_sel | output | 1 | ALU second operand: 1 = immediate, 0 = register |
| wb_sel | output | 1 | Register write data: 1 = memory, 0 = ALU |
| rf_we | output | 1 | Register file write enable |
| dmem_re | output | 1 | Data memory read enable |
| dmem_we | output | 1 | Data memory write enable |
| op_class | output | 2 | ALU-operation class |
| br | output | 1 | Branch instruction line |
| alu_op | output | 3 | Decoded ALU operation |
| pc_sel | output | 1 | Next PC: 1 = branch target, 0 = PC+4 |

## Verification
Two functions can act in the same evaluation:

- the function-field sub-decode, which sets the ALU operation;
- the zero-gated branch, which sets the next PC.

The bench applies mixed opcode, function and zero values together, and every combination is judged in one settle. This confirms two things. The function field changes alu_op only for register-register opcodes. The zero flag moves pc_sel only for the branch opcode. Random vectors are weighted toward the four known opcodes and the five known function codes. Directed vectors pin the unknown-opcode and unknown-function defaults.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int CLASS_W = 2;
    localparam int AOP_W   = 3;

    localparam logic [OPC_W-1:0] OPC_RR  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_ST  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    typedef enum logic [CLASS_W-1:0] {
        CLS_ADD  = 2'b00,
        CLS_SUB  = 2'b01,
        CLS_FUNC = 2'b10,
        CLS_RSVD = 2'b11
    } op_class_e;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD = 3'd0,
        AOP_SUB = 3'd1,
        AOP_AND = 3'd2,
        AOP_OR  = 3'd3,
        AOP_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic      dst_sel;
        logic      opb_sel;
        logic      wb_sel;
        logic      rf_we;
        logic      dmem_re;
        logic      dmem_we;
        op_class_e op_class;
        logic      br;
    } ctrl_lines_t;

    localparam ctrl_lines_t CTRL_IDLE = '{
        dst_sel: 1'b0, opb_sel: 1'b0, wb_sel: 1'b0, rf_we: 1'b0,
        dmem_re: 1'b0, dmem_we: 1'b0, op_class: CLS_ADD, br: 1'b0};

    function automatic alu_op_e fn_to_aop(input logic [FN_W-1:0] fn);
        alu_op_e r;
        unique case (fn)
            FN_ADD:  r = AOP_ADD;
            FN_SUB:  r = AOP_SUB;
            FN_AND:  r = AOP_AND;
            FN_OR:   r = AOP_OR;
            FN_SLT:  r = AOP_SLT;
            default: r = AOP_ADD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/main_decoder.sv
module main_decoder
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ctrl_lines_t      lines
);
    always_comb begin
        lines = CTRL_IDLE;
        unique case (opcode)
            OPC_RR: begin
                lines.dst_sel  = 1'b1;
                lines.rf_we    = 1'b1;
                lines.op_class = CLS_FUNC;
            end
            OPC_LD: begin
                lines.opb_sel  = 1'b1;
                lines.wb_sel   = 1'b1;
                lines.rf_we    = 1'b1;
                lines.dmem_re  = 1'b1;
            end
            OPC_ST: begin
                lines.opb_sel  = 1'b1;
                lines.dmem_we  = 1'b1;
            end
            OPC_BEQ: begin
                lines.op_class = CLS_SUB;
                lines.br       = 1'b1;
            end
            default: lines = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
    import ctrl_pkg::*;
(
    input  op_class_e       op_class,
    input  logic [FN_W-1:0] funct,
    output alu_op_e         alu_op
);
    always_comb begin
        unique case (op_class)
            CLS_SUB:  alu_op = AOP_SUB;
            CLS_FUNC: alu_op = fn_to_aop(funct);
            default:  alu_op = AOP_ADD;
        endcase
    end
endmodule

// File: rtl/pc_select.sv
module pc_select (
    input  logic br,
    input  logic alu_zero,
    output logic pc_sel
);
    assign pc_sel = br & alu_zero;
endmodule

// File: rtl/cpu_ctrl_unit.sv
module cpu_ctrl_unit
    import ctrl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       alu_zero,
    output logic       dst_sel,
    output logic       opb_sel,
    output logic       wb_sel,
    output logic       rf_we,
    output logic       dmem_re,
    output logic       dmem_we,
    output logic [1:0] op_class,
    output logic       br,
    output logic [2:0] alu_op,
    output logic       pc_sel
);
    ctrl_lines_t lines;
    alu_op_e     aop;

    main_decoder u_main (.opcode(opcode), .lines(lines));
    alu_ctrl     u_aluc (.op_class(lines.op_class), .funct(funct), .alu_op(aop));
    pc_select    u_pcs  (.br(lines.br), .alu_zero(alu_zero), .pc_sel(pc_sel));

    assign dst_sel  = lines.dst_sel;
    assign opb_sel  = lines.opb_sel;
    assign wb_sel   = lines.wb_sel;
    assign rf_we    = lines.rf_we;
    assign dmem_re  = lines.dmem_re;
    assign dmem_we  = lines.dmem_we;
    assign op_class = lines.op_class;
    assign br       = lines.br;
    assign alu_op   = aop;
endmodule

// File: rtl/cpu_ctrl_unit_chk.sv
module cpu_ctrl_unit_chk (
    input logic [5:0] opcode,
    input logic       alu_zero,
    input logic       rf_we,
    input logic       dmem_re,
    input logic       dmem_we,
    input logic       wb_sel,
    input logic       dst_sel,
    input logic [1:0] op_class,
    input logic       br,
    input logic [2:0] alu_op,
    input logic       pc_sel
);
    always_comb begin
        if (!$isunknown({opcode, alu_zero, rf_we, dmem_re, dmem_we, wb_sel,
                         dst_sel, op_class, br, alu_op, pc_sel})) begin
            // R1, R2: register write only for register-register or load
            p_we_source_r2: assert (!rf_we || opcode == 6'b000000 || opcode == 6'b100011);
            // R9: memory never read and written together
            p_mem_excl_r9: assert (!(dmem_re && dmem_we));
            // R8: branch target only with branch line and zero flag
            p_pc_gate_r8: assert (!pc_sel || (br && alu_zero));
            // R2: memory read implies write data comes from memory
            p_load_wb_r2: assert (!dmem_re || wb_sel);
            // R6: subtract class always yields subtract
            p_sub_class_r6: assert (op_class != 2'b01 || alu_op == 3'd1);
            // R1: function-decode class only with rd destination
            p_func_dst_r1: assert (op_class != 2'b10 || dst_sel);
        end
    end
endmodule

bind cpu_ctrl_unit cpu_ctrl_unit_chk u_chk (
    .opcode(opcode), .alu_zero(alu_zero), .rf_we(rf_we), .dmem_re(dmem_re),
    .dmem_we(dmem_we), .wb_sel(wb_sel), .dst_sel(dst_sel), .op_class(op_class),
    .br(br), .alu_op(alu_op), .pc_sel(pc_sel)
);

// File: tb/cpu_ctrl_unit_tb.sv
module cpu_ctrl_unit_tb;
    logic clk = 1'b0;
    logic rst;
    logic [5:0] opcode, funct;
    logic alu_zero;
    logic dst_sel, opb_sel, wb_sel, rf_we, dmem_re, dmem_we, br, pc_sel;
    logic [1:0] op_class;
    logic [2:0] alu_op;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_ctrl_unit u_dut (
        .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
        .dst_sel(dst_sel), .opb_sel(opb_sel), .wb_sel(wb_sel), .rf_we(rf_we),
        .dmem_re(dmem_re), .dmem_we(dmem_we), .op_class(op_class), .br(br),
        .alu_op(alu_op), .pc_sel(pc_sel)
    );

    // {dst,opb,wb,we,re,wr,class[1:0],br}
    function automatic logic [8:0] exp_lines(input logic [5:0] op);
        case (op)
            6'b000000: return 9'b1_0_0_1_0_0_10_0;
            6'b100011: return 9'b0_1_1_1_1_0_00_0;
            6'b101011: return 9'b0_1_0_0_0_1_00_0;
            6'b000100: return 9'b0_0_0_0_0_0_01_1;
            default:   return 9'b0;
        endcase
    endfunction

    function automatic string lines_req(input logic [5:0] op);
        case (op)
            6'b000000: return "R1";
            6'b100011: return "R2";
            6'b101011: return "R3";
            6'b000100: return "R4";
            default:   return "R5";
        endcase
    endfunction

    function automatic logic [2:0] exp_aop(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'b000100) return 3'd1;
        if (op != 6'b000000) return 3'd0;
        case (fn)
            6'b100010: return 3'd1;
            6'b100100: return 3'd2;
            6'b100101: return 3'd3;
            6'b101010: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s op=%b fn=%b z=%b actual=%0h expected=%0h",
                     req, opcode, funct, alu_zero, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
        logic [8:0] el;
        logic [2:0] ea;
        @(negedge clk);
        opcode = op; funct = fn; alu_zero = z;
        #2;
        el = exp_lines(op);
        ea = exp_aop(op, fn);
        chk({dst_sel, opb_sel, wb_sel, rf_we, dmem_re, dmem_we, op_class, br} == el,
            lines_req(op), int'({dst_sel, opb_sel, wb_sel, rf_we, dmem_re, dmem_we, op_class, br}),
            int'(el));
        chk(alu_op == ea, (op == 6'b000000) ? "R7" : "R6", int'(alu_op), int'(ea));
        chk(pc_sel == (op == 6'b000100 && z), "R8", int'(pc_sel), int'(op == 6'b000100 && z));
        chk(!(dmem_re && dmem_we), "R9", int'({dmem_re, dmem_we}), 0);
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [5:0] known_op [4];
        logic [5:0] known_fn [5];
        known_op = '{6'b000000, 6'b100011, 6'b101011, 6'b000100};
        known_fn = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        void'($urandom(32'd2024));
        rst = 1'b1; opcode = '0; funct = '0; alu_zero = 1'b0;
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs decode as register-register, add default
        apply(6'b000000, 6'b000000, 1'b0);
        rst = 1'b0;
        // directed corners
        apply(6'b000100, 6'b101010, 1'b1);   // R8 taken, R6 function ignored
        apply(6'b000100, 6'b100100, 1'b0);   // R8 not taken
        apply(6'b000000, 6'b101010, 1'b1);   // R7 slt, R8 zero ignored
        apply(6'b000000, 6'b111111, 1'b0);   // R7 unknown function -> add
        apply(6'b100011, 6'b100010, 1'b1);   // R2, R6 function ignored
        apply(6'b101011, 6'b100101, 1'b0);   // R3
        apply(6'b111111, 6'b100010, 1'b1);   // R5
        apply(6'b000101, 6'b100100, 1'b1);   // R5 near-branch opcode
        for (int i = 0; i < 5; i++) apply(6'b000000, known_fn[i], 1'(i));
        for (int i = 0; i < 64; i++) apply(6'(i), 6'b100010, 1'b1);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op, fn;
            op = ($urandom % 4 != 0) ? known_op[$urandom % 4] : 6'($urandom);
            fn = ($urandom % 4 != 0) ? known_fn[$urandom % 5] : 6'($urandom);
            apply(op, fn, 1'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule